// File: doc/BRIEF.md
# Lowest-Index Priority Encoder

This block is a purely combinational encoder. It takes a request vector and returns the position of the least-significant set bit as a binary code. A separate active-high flag shows that no request bit is set. The block has no clock, no reset and no storage, so every output is a function of the present input alone.

Inside, a selection stage first reduces the request vector to a one-hot vector. That vector keeps only the lowest set bit. A binary encoding stage then turns the one-hot vector into the code and the empty flag. A parameter picks how the selection stage is built. One variant uses an arithmetic two's-complement mask. The other uses a ripple chain that scans upward from bit 0 with a "found" signal. Both variants produce the same result. When no bit is set, the code is forced to zero so that the outputs are always deterministic.

Top module: `lsb_prio_enc`

## Requirements
- R1: `empty_o` is 1 exactly when every bit of `req_i` is 0.
- R2: `empty_o` is 0 whenever at least one bit of `req_i` is 1.
- R3: When at least one request bit is set, `code_o` equals the unsigned binary index of the lowest-numbered set bit of `req_i`, where bit 0 is the least significant.
- R4: When `req_i` is all zeros, `code_o` is driven to 0.
- R5: Request bits above the lowest set bit have no effect on `code_o` or `empty_o`. For example, `req_i` = 8'h01 and 8'h FF both give code 0.
- R6: The outputs depend only on the present input. The same `req_i` gives the same outputs whatever pattern was applied before it, and the outputs settle within the cycle in which the input changes.
- R7: The arithmetic selection variant (`SEL_STYLE` = SEL_ARITH) and the ripple-chain variant (`SEL_STYLE` = SEL_CHAIN) give identical outputs for every input.
- R8: For a request width that is not a power of two, the code is $clog2(WIDTH) bits wide and still encodes the lowest set index correctly. For WIDTH = 5 the code is 3 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_i | input | WIDTH | Request vector; bit 0 has the highest priority |
| code_o | output | $clog2(WIDTH) | Binary index of the lowest set request bit; 0 when none is set |
| empty_o | output | 1 | High when no request bit is set |

## Verification
The bench builds three copies of the encoder:
- **8-bit, arithmetic selection:** this instance sweeps all 256 request patterns exhaustively.
- **8-bit, ripple chain:** this instance gets the same 256 patterns, so the two selection variants can be compared pattern by pattern against one reference.
- **5-bit:** this instance gets all 32 of its patterns. It brings the non-power-of-two case within reach, where the code width is rounded up and the top code values are never produced.

Directed sequences revisit the same pattern after different predecessors. They also pair vectors that share their lowest set bit but differ in the higher bits.

// File: rtl/lpe_pkg.sv
package lpe_pkg;

   // Build variant of the lowest-bit selection stage
   typedef enum logic [0:0] {
      SEL_ARITH = 1'b0,   // two's-complement mask: r & (~r + 1)
      SEL_CHAIN = 1'b1    // upward ripple with a found flag
   } sel_style_e;

   function automatic int code_width(input int w);
      return (w < 2) ? 1 : $clog2(w);
   endfunction

endpackage

// File: rtl/lpe_lowest_sel.sv
module lpe_lowest_sel #(
   parameter int                 WIDTH     = 8,
   parameter lpe_pkg::sel_style_e SEL_STYLE = lpe_pkg::SEL_ARITH
) (
   input  logic [WIDTH-1:0] req_i,
   output logic [WIDTH-1:0] onehot_o
);

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   if (WIDTH < 2) begin : g_bad_width
      $error("lpe_lowest_sel: WIDTH must be at least 2");
   end

   // Consistency checks on the selection, evaluated in the producing process
   task automatic check_sel(input logic [WIDTH-1:0] r, input logic [WIDTH-1:0] oh);
      // R5
      sel_onehot_chk: assert ($onehot0(oh))
         else $error("selection is not one-hot");
      // R1
      sel_empty_chk: assert ((oh == '0) == (r == '0))
         else $error("selection empty mismatch");
      // R3
      sel_subset_chk: assert ((oh & ~r) == '0)
         else $error("selected bit not requested");
      // R3
      sel_lower_clear_chk: assert ((r & (oh - ONE)) == '0)
         else $error("a lower request bit was skipped");
   endtask

   if (SEL_STYLE == lpe_pkg::SEL_ARITH) begin : g_arith
      always_comb begin
         onehot_o = req_i & (~req_i + ONE);
         check_sel(req_i, onehot_o);
      end
   end else if (SEL_STYLE == lpe_pkg::SEL_CHAIN) begin : g_chain
      always_comb begin
         logic found;
         found = 1'b0;
         for (int i = 0; i < WIDTH; i++) begin
            onehot_o[i] = req_i[i] & ~found;
            found       = found | req_i[i];
         end
         check_sel(req_i, onehot_o);
      end
   end else begin : g_bad_style
      $error("lpe_lowest_sel: unknown SEL_STYLE");
   end

endmodule

// File: rtl/lpe_onehot_enc.sv
module lpe_onehot_enc #(
   parameter int WIDTH  = 8,
   parameter int CODE_W = lpe_pkg::code_width(WIDTH)
) (
   input  logic [WIDTH-1:0]  onehot_i,
   output logic [CODE_W-1:0] code_o,
   output logic              empty_o
);

   if (CODE_W < lpe_pkg::code_width(WIDTH)) begin : g_bad_code_w
      $error("lpe_onehot_enc: CODE_W too small for WIDTH");
   end

   always_comb begin
      code_o  = '0;
      empty_o = 1'b1;
      for (int i = 0; i < WIDTH; i++) begin
         if (onehot_i[i]) begin
            code_o  = code_o | CODE_W'(i);
            empty_o = 1'b0;
         end
      end
      // R4
      enc_zero_code_chk: assert (!empty_o || code_o == '0)
         else $error("code not zero while empty");
      // R3
      enc_index_chk: assert (empty_o || onehot_i[code_o])
         else $error("code does not point at the selected bit");
      // R8
      enc_range_chk: assert (int'(code_o) < WIDTH)
         else $error("code beyond request width");
   end

endmodule

// File: rtl/lsb_prio_enc.sv
module lsb_prio_enc #(
   parameter int                 WIDTH     = 8,
   parameter lpe_pkg::sel_style_e SEL_STYLE = lpe_pkg::SEL_ARITH,
   localparam int                CODE_W    = lpe_pkg::code_width(WIDTH)
) (
   input  logic [WIDTH-1:0]  req_i,
   output logic [CODE_W-1:0] code_o,
   output logic              empty_o
);

   logic [WIDTH-1:0] onehot;

   lpe_lowest_sel #(
      .WIDTH     (WIDTH),
      .SEL_STYLE (SEL_STYLE)
   ) i_sel (
      .req_i    (req_i),
      .onehot_o (onehot)
   );

   lpe_onehot_enc #(
      .WIDTH  (WIDTH),
      .CODE_W (CODE_W)
   ) i_enc (
      .onehot_i (onehot),
      .code_o   (code_o),
      .empty_o  (empty_o)
   );

endmodule

// File: tb/test_lsb_prio_enc.sv
module test_lsb_prio_enc;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic [7:0] req8;
   logic [2:0] code_a, code_c, code_5;
   logic       empty_a, empty_c, empty_5;
   logic [4:0] req5;

   int compared   = 0;
   int mismatched = 0;
   bit done       = 1'b0;

   lsb_prio_enc #(.WIDTH(8), .SEL_STYLE(lpe_pkg::SEL_ARITH)) i_lsb_prio_enc (
      .req_i(req8), .code_o(code_a), .empty_o(empty_a));

   lsb_prio_enc #(.WIDTH(8), .SEL_STYLE(lpe_pkg::SEL_CHAIN)) i_lsb_prio_enc_chain (
      .req_i(req8), .code_o(code_c), .empty_o(empty_c));

   lsb_prio_enc #(.WIDTH(5), .SEL_STYLE(lpe_pkg::SEL_ARITH)) i_lsb_prio_enc_w5 (
      .req_i(req5), .code_o(code_5), .empty_o(empty_5));

   // Behavioural reference: scan upward from bit 0, -1 when nothing is set
   function automatic int ref_lowest(input logic [7:0] v, input int w);
      for (int i = 0; i < w; i++)
         if (v[i]) return i;
      return -1;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s req8=%02h req5=%02h actual=%0d expected=%0d",
                  req, req8, req5, act, exp);
      end
   endtask

   // Compare all three instances against the reference for the applied input
   task automatic check_all(input string tag);
      int l8 = ref_lowest(req8, 8);
      int l5 = ref_lowest({3'b0, req5}, 5);
      check({tag, " R1/R2 empty arith"}, int'(empty_a), (l8 < 0) ? 1 : 0);
      check({tag, " R1/R2 empty chain"}, int'(empty_c), (l8 < 0) ? 1 : 0);
      if (l8 >= 0) begin
         check({tag, " R3 code arith"}, int'(code_a), l8);
         check({tag, " R3 code chain"}, int'(code_c), l8);
      end else begin
         check({tag, " R4 code arith"}, int'(code_a), 0);
         check({tag, " R4 code chain"}, int'(code_c), 0);
      end
      check({tag, " R7 variants agree"}, int'({code_c, empty_c}), int'({code_a, empty_a}));
      check({tag, " R8 empty w5"}, int'(empty_5), (l5 < 0) ? 1 : 0);
      check({tag, " R8 code w5"}, int'(code_5), (l5 < 0) ? 0 : l5);
   endtask

   // Apply at a rising edge, sample at the following falling edge
   task automatic apply(input logic [7:0] v, input string tag);
      @(posedge clk);
      req8 = v;
      req5 = v[4:0];
      @(negedge clk);
      check_all(tag);
   endtask

   initial begin
      req8 = '0;
      req5 = '0;
      #1;
      // initial state with all-zero request
      check("R1 empty at start", int'(empty_a), 1);
      check("R4 code at start", int'(code_a), 0);

      // Exhaustive sweep of all 256 patterns (R1 R2 R3 R4 R7 R8)
      for (int v = 0; v < 256; v++) apply(8'(v), "sweep");

      // R5: higher bits do not alter the result
      apply(8'h01, "R5 low only");
      check("R5 code for 01", int'(code_a), 0);
      apply(8'hFF, "R5 all set");
      check("R5 code for FF", int'(code_a), 0);
      apply(8'h10, "R5 bit4");
      check("R5 code for 10", int'(code_a), 4);
      apply(8'hF0, "R5 bits7..4");
      check("R5 code for F0", int'(code_a), 4);
      apply(8'h80, "R3 top bit");
      check("R3 code for 80", int'(code_a), 7);

      // R6: same pattern after different predecessors gives the same result
      apply(8'h80, "R6 pre hi");
      apply(8'h24, "R6 after 80");
      check("R6 code 24 after 80", int'(code_a), 2);
      apply(8'h00, "R6 pre zero");
      apply(8'h24, "R6 after 00");
      check("R6 code 24 after 00", int'(code_a), 2);
      apply(8'h01, "R6 pre low");
      apply(8'h00, "R6 zero after 01");
      check("R6 empty after 01", int'(empty_a), 1);
      check("R6 code zero after 01", int'(code_a), 0);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            compared++;
            mismatched++;
            $display("FAIL watchdog expired actual=running expected=done");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule